// File: doc/BRIEF.md
# Low-Power Ship Mode Controller

This block parks a battery-powered device in a deep shipping state and brings it back out. Software configures it through a single 32-bit register write. Readback returns the stored configuration. The block runs entirely on the slow RC clock of the always-on domain.

Entry into ship mode happens in one of two ways. Software can write a 16-bit magic key, or, when enabled, a falling edge on a selected combination of two battery-domain pins triggers it. Exit happens on a rising edge of that same pin combination. The controller then holds a reset output for a programmable number of clocks before returning to normal operation.

The pins are asynchronous. Each passes through a two-flop synchronizer, and edges are taken on the combined condition rather than on each pin.

Top module: `ship_mode_ctrl`

## Requirements
- R1: After reset, `ship_active` and `reset_hold` are 0 and `rd_data` reads 0.
- R2: A write whose bits 15:0 equal 0xAAAA moves the block from normal operation into ship mode at that clock edge. Any other value in bits 15:0 has no effect on the state.
- R3: Bits 15:0 and bits 31:22 always read as 0. Bits 17:16 (wake select), bit 18 (pin-entry enable) and bits 21:19 (hold count) read back the last written value.
- R4: The wake condition is chosen by bits 17:16: 0 selects pin A, 1 selects pin B, 2 selects A AND B, and 3 selects A OR B.
- R5: In ship mode, a rising edge of the wake condition ends ship mode. `reset_hold` rises 3 clock edges after the pin change: two for the synchronizer and one for the state register. A pin change that leaves the condition low has no effect.
- R6: On exit, `reset_hold` stays high for exactly N cycles, where N is the hold count, and then the block returns to normal operation.
- R7: A hold count of 0 still asserts `reset_hold` for exactly one cycle.
- R8: With bit 18 set, a falling edge of the wake condition in normal operation enters ship mode 3 edges after the pin change. With bit 18 clear, such a falling edge has no effect.
- R9: Rising edges of the wake condition during normal operation are ignored. `ship_active` and `reset_hold` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz RC clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register readback |
| pin_a | input | 1 | Asynchronous wake/entry pin A |
| pin_b | input | 1 | Asynchronous wake/entry pin B |
| ship_active | output | 1 | High while in ship mode |
| reset_hold | output | 1 | High while the exit reset is held |

## Verification
The assertions check the following on every cycle:
- the outputs are mutually exclusive;
- the key field reads back as zero;
- a key write in normal operation is followed by ship mode;
- ship mode persists without a wake edge and ends in reset hold with one;
- reset hold never runs past its maximum length.

The following can only be shown by the bench's scenarios:
- the exact hold length for each count;
- the three-edge latency through the synchronizer;
- the truth table of each wake selection;
- the gating of pin entry by its enable bit.

// File: rtl/smc_pkg.sv
package smc_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_SHIP   = 2'd1,
    ST_EXIT   = 2'd2
  } smc_state_t;

  // Combined wake condition for a selector value
  function automatic logic wake_cond(input logic [1:0] sel, input logic a, input logic b);
    case (sel)
      2'd0:    return a;
      2'd1:    return b;
      2'd2:    return a & b;
      default: return a | b;
    endcase
  endfunction

  // Number of reset-hold cycles for a programmed count (0 means 1)
  function automatic int unsigned hold_cycles(input int unsigned n);
    return (n == 0) ? 1 : n;
  endfunction

endpackage

// File: rtl/smc_sync.sv
module smc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_async[i]};
    end
    assign q_sync[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/smc_edge_detect.sv
module smc_edge_detect
  import smc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       a_sync,
  input  logic       b_sync,
  output logic       rise,
  output logic       fall
);
  logic cond, cond_q;

  assign cond = wake_cond(sel, a_sync, b_sync);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond;
  end

  assign rise = cond & ~cond_q;
  assign fall = ~cond & cond_q;
endmodule

// File: rtl/smc_hold_timer.sv
module smc_hold_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/ship_mode_ctrl.sv
module ship_mode_ctrl
  import smc_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          HOLD_W      = 3,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] MAGIC       = 16'hAAAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pin_a,
  input  logic              pin_b,
  output logic              ship_active,
  output logic              reset_hold
);
  localparam int KEY_W   = 16;
  localparam int SEL_LSB = KEY_W;
  localparam int ENT_BIT = SEL_LSB + 2;
  localparam int HLD_LSB = ENT_BIT + 1;
  localparam int HLD_MSB = HLD_LSB + HOLD_W - 1;

  logic [1:0]        cfg_sel;
  logic              cfg_entry_en;
  logic [HOLD_W-1:0] cfg_hold;

  logic [1:0]  pins_sync;
  logic        wake_rise, wake_fall, magic_hit, hold_done, hold_load;
  smc_state_t  state, state_nx;

  // Configuration register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_sel      <= '0;
      cfg_entry_en <= 1'b0;
      cfg_hold     <= '0;
    end else if (wr_en) begin
      cfg_sel      <= wr_data[SEL_LSB+1:SEL_LSB];
      cfg_entry_en <= wr_data[ENT_BIT];
      cfg_hold     <= wr_data[HLD_MSB:HLD_LSB];
    end
  end

  always_comb begin
    rd_data                  = '0;
    rd_data[SEL_LSB+1:SEL_LSB] = cfg_sel;
    rd_data[ENT_BIT]         = cfg_entry_en;
    rd_data[HLD_MSB:HLD_LSB] = cfg_hold;
  end

  assign magic_hit = wr_en && (wr_data[KEY_W-1:0] == MAGIC);

  smc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({pin_b, pin_a}),
    .q_sync  (pins_sync)
  );

  smc_edge_detect u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (cfg_sel),
    .a_sync (pins_sync[0]),
    .b_sync (pins_sync[1]),
    .rise   (wake_rise),
    .fall   (wake_fall)
  );

  // Loads hold_cycles(N)-1 so that EXIT lasts hold_cycles(N) cycles
  logic [HOLD_W-1:0] hold_init;
  assign hold_init = HOLD_W'(hold_cycles(int'(cfg_hold)) - 1);

  smc_hold_timer #(.CNT_W(HOLD_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (hold_load),
    .load_val (hold_init),
    .done     (hold_done)
  );

  always_comb begin
    state_nx  = state;
    hold_load = 1'b0;
    case (state)
      ST_ACTIVE: if (magic_hit || (cfg_entry_en && wake_fall)) state_nx = ST_SHIP;
      ST_SHIP:   if (wake_rise) begin
                   state_nx  = ST_EXIT;
                   hold_load = 1'b1;
                 end
      ST_EXIT:   if (hold_done) state_nx = ST_ACTIVE;
      default:   state_nx = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_ACTIVE;
    else        state <= state_nx;
  end

  assign ship_active = (state == ST_SHIP);
  assign reset_hold  = (state == ST_EXIT);

endmodule

// File: rtl/ship_mode_ctrl_chk.sv
module ship_mode_ctrl_chk #(
  parameter int HOLD_W = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] rd_data,
  input logic        ship_active,
  input logic        reset_hold,
  input logic        magic_hit,
  input logic        wake_rise
);
  localparam int HOLD_MAX = 2 ** HOLD_W;
  logic [HOLD_W+1:0] hold_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hold_run <= '0;
    else if (reset_hold) hold_run <= hold_run + 1'b1;
    else                 hold_run <= '0;
  end

  // R9
  outputs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ship_active, reset_hold}));

  // R3
  key_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15:0] == 16'h0);

  // R2
  magic_enters_ship_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (magic_hit && !ship_active && !reset_hold) |=> ship_active);

  // R5
  ship_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ship_active && !wake_rise) |=> ship_active);

  // R5
  wake_exits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ship_active && wake_rise) |=> (reset_hold && !ship_active));

  // R6
  hold_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_run <= HOLD_MAX);
endmodule

bind ship_mode_ctrl ship_mode_ctrl_chk #(.HOLD_W(HOLD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_data     (rd_data),
  .ship_active (ship_active),
  .reset_hold  (reset_hold),
  .magic_hit   (magic_hit),
  .wake_rise   (wake_rise)
);

// File: tb/ship_mode_ctrl_bench.sv
module ship_mode_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pin_a = 1'b0, pin_b = 1'b0;
  logic        ship_active, reset_hold;
  int          n_checks = 0, n_fail = 0;

  always #10 clk = ~clk;

  ship_mode_ctrl u_ship_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pin_a(pin_a), .pin_b(pin_b), .ship_active(ship_active), .reset_hold(reset_hold)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cfg_word(input int sel, input int ent, input int hold,
                                           input logic [15:0] key);
    return {10'b0, 3'(hold), 1'(ent), 2'(sel), key};
  endfunction

  task automatic write_reg(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic set_pins(input logic a, input logic b);
    @(negedge clk);
    pin_a = a; pin_b = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ship_active", ship_active, 0);
    check("R1 reset_hold", reset_hold, 0);
    check("R1 rd_data", rd_data, 0);

    // R3 readback masks key and reserved bits; R2 wrong key ignored
    write_reg(32'hFFC0_0000 | cfg_word(2, 1, 5, 16'h1234));
    check("R3 readback", rd_data, cfg_word(2, 1, 5, 16'h0));
    check("R2 wrong key no entry", ship_active, 0);
    write_reg(cfg_word(0, 0, 0, 16'hAAAB));
    check("R2 near key no entry", ship_active, 0);

    // R4 R5 R6 R7 sweep: every selector and every hold count
    for (int sel = 0; sel < 4; sel++) begin
      for (int hold = 0; hold < 8; hold++) begin
        logic na, nb;
        int lat, len, exp_len;
        exp_len = (hold == 0) ? 1 : hold;
        // R4: pins that leave the condition low
        na = (sel == 1 || sel == 2); nb = (sel == 0);
        write_reg(cfg_word(sel, 0, hold, 16'hAAAA));
        check("R2 key entry", ship_active, 1);
        set_pins(na, nb);
        idle(5);
        check("R4 non-qualifying pins ignored", {ship_active, reset_hold}, 2'b10);
        // R5: qualifying rising edge
        @(negedge clk); pin_a = 1'b1; pin_b = 1'b1;
        lat = 0;
        while (!reset_hold && lat < 8) begin @(negedge clk); lat++; end
        check("R5 exit latency", lat, 3);
        len = 0;
        while (reset_hold && len < 12) begin
          if (ship_active) check("R9 exclusive", ship_active, 0);
          @(negedge clk); len++;
        end
        // R6 R7 hold length
        check(hold == 0 ? "R7 zero hold length" : "R6 hold length", len, exp_len);
        check("R6 back to normal", {ship_active, reset_hold}, 2'b00);
        // R8: falling edge with entry disabled is ignored
        set_pins(0, 0);
        idle(5);
        check("R8 fall ignored when disabled", {ship_active, reset_hold}, 2'b00);
      end
    end

    // R9 rising edges in normal operation ignored
    write_reg(cfg_word(3, 0, 2, 16'h0));
    set_pins(1, 0); idle(5);
    check("R9 rise in normal ignored", {ship_active, reset_hold}, 2'b00);
    set_pins(0, 0); idle(4);

    // R8 pin-driven entry on falling edge, OR selection
    write_reg(cfg_word(3, 1, 2, 16'h0));
    set_pins(1, 1); idle(5);
    check("R9 rise before entry ignored", {ship_active, reset_hold}, 2'b00);
    @(negedge clk); pin_a = 1'b0; pin_b = 1'b0;
    idle(2);
    check("R8 not yet entered", ship_active, 0);
    idle(1);
    check("R8 fall entry", ship_active, 1);
    // R2 key write while in ship mode keeps state
    write_reg(cfg_word(3, 1, 2, 16'hAAAA));
    check("R2 key in ship stays", {ship_active, reset_hold}, 2'b10);
    // R4 OR: pin B alone wakes
    set_pins(0, 1); idle(3);
    check("R4 OR wake via B", {ship_active, reset_hold}, 2'b01);
    idle(2);
    check("R6 hold of 2 ended", {ship_active, reset_hold}, 2'b00);
    set_pins(0, 0); idle(3);
    // R8 fall re-enters when enabled
    check("R8 re-entry on fall", ship_active, 1);

    finish_run();
  end
endmodule